// File: doc/BRIEF.md
# DS3 Transmit M-Frame Aligner

This block sits at the serial input of a DS3 transmitter. It takes the incoming bit stream, one bit per transmit clock, and places every bit at a known position inside the 4760-bit M-frame. That frame is built from 7 subframes. Each subframe holds 8 blocks, and each block is 85 bits long. The first bit of every block is an overhead slot and the other 84 bits are payload. The block forwards the stream to a single NRZ output with a fixed latency of two clocks. In each overhead slot it either keeps the placeholder bit that arrived in the stream or puts in a bit from an internal overhead source.

The frame position comes from an external sync pulse when one is supplied. A pulse reloads the position counter to bit 0. With no pulse, for example when the sync input is tied low, the counter runs freely and wraps every 4760 bits. A sync output marks the first bit of each frame at the NRZ output, so logic further down the line can lock to whichever reference is in use. One clock before each overhead bit leaves the block, it raises a strobe together with the subframe and block numbers of that slot. The overhead source has that clock to present the matching bit.

Top module: `ds3_mframe_aligner`

## Requirements
- R1: While rst_n is low, nrz_out, sync_out and oh_slot are 0, and sub_idx and blk_idx are 0.
- R2: A payload bit that is valid on data_in at the falling clock edge of bit period k appears on nrz_out throughout bit period k+2. A bit period runs from one rising edge to the next.
- R3: data_in is sampled only at the falling edge of clk. A change of data_in between the falling edge and the next rising edge has no effect on nrz_out.
- R4: sync_in is sampled only at the rising edge of clk. A high level that starts after a falling edge and ends before the next rising edge has no effect on the frame position.
- R5: After reset with sync_in held low, the bit sampled in the first bit period after reset is frame position 0. sync_out is high for one clock in bit period 2, and after that once every 4760 clocks.
- R6: If sync_in is high at a rising edge, the bit of the period that edge opens is frame position 0. sync_out is high two periods later, and the count continues from there.
- R7: Frame position p is an overhead slot when p mod 85 equals 0. oh_slot is high in the period just before that bit's NRZ period, and at no other time.
- R8: With ext_oh_en low at the rising edge that opens the NRZ period of an overhead slot, nrz_out carries the oh_bit value sampled at that same edge.
- R9: With ext_oh_en high at that edge, the placeholder bit from data_in goes through to nrz_out unchanged.
- R10: Payload positions always carry data_in, whatever the values of oh_bit and ext_oh_en.
- R11: While oh_slot is high, blk_idx is (p / 85) mod 8 and sub_idx is p / 680. Both count up from 0, blk_idx every 85 bits and sub_idx every 680 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_in | input | 1 | External frame sync, sampled on the rising edge; tie low to run from the internal counter |
| data_in | input | 1 | Serial transmit data with placeholder overhead bits, sampled on the falling edge |
| ext_oh_en | input | 1 | 1: keep overhead bits from data_in; 0: insert oh_bit |
| oh_bit | input | 1 | Overhead bit from the internal source, sampled at the end of a strobe period |
| nrz_out | output | 1 | Aligned NRZ output |
| sync_out | output | 1 | High for the first frame bit on nrz_out |
| oh_slot | output | 1 | Strobe: the next NRZ bit is an overhead slot |
| sub_idx | output | 3 | Subframe number of the strobed slot |
| blk_idx | output | 3 | Block number of the strobed slot |

## Verification
The main path is driven with a pseudo-random data stream and an independent random overhead source. An error in latency, in slot selection or in the insert/keep choice therefore shows up as a bit that differs at the output. A free run over two whole frames checks wrap and pulse spacing against reset alignment. External sync pulses at mid-block offsets, including back-to-back pulses, show whether the counter really reloads or only runs in step by chance. Short glitches on data and sync, placed between the falling edge and the next rising edge, separate correct edge sampling from level sampling. A run with overhead insertion disabled separates keeping the placeholders from replacing them.

// File: rtl/ds3_align_pkg.sv
package ds3_align_pkg;

    // DS3 M-frame geometry defaults
    localparam int unsigned BLOCK_BITS_DEF = 85;
    localparam int unsigned BLOCKS_DEF     = 8;
    localparam int unsigned SUBFRAMES_DEF  = 7;

    // Source selected for the NRZ output bit
    typedef enum logic [1:0] {
        SRC_PAYLOAD   = 2'd0,
        SRC_OH_KEEP   = 2'd1,
        SRC_OH_INSERT = 2'd2
    } nrz_src_e;

endpackage

// File: rtl/ds3_neg_sampler.sv
module ds3_neg_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    typedef struct packed {
        logic bit_v;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d       = smp_q;
        smp_d.bit_v = din;
    end

    // Data capture on the falling edge of the bit clock
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign dout = smp_q.bit_v;

endmodule

// File: rtl/ds3_frame_counter.sv
module ds3_frame_counter #(
    parameter  int unsigned BLK_BITS = ds3_align_pkg::BLOCK_BITS_DEF,
    parameter  int unsigned BLKS     = ds3_align_pkg::BLOCKS_DEF,
    parameter  int unsigned SUBS     = ds3_align_pkg::SUBFRAMES_DEF,
    localparam int unsigned BIT_W    = $clog2(BLK_BITS),
    localparam int unsigned BLK_W    = $clog2(BLKS),
    localparam int unsigned SUB_W    = $clog2(SUBS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    output logic [BIT_W-1:0] bit_pos,
    output logic [BLK_W-1:0] blk_pos,
    output logic [SUB_W-1:0] sub_pos,
    output logic             at_oh,
    output logic             at_start
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BLK_BITS - 1);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(BLKS - 1);
    localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(SUBS - 1);

    typedef struct packed {
        logic [BIT_W-1:0] bpos;
        logic [BLK_W-1:0] blk;
        logic [SUB_W-1:0] sub;
    } pos_t;

    // Reset value is the last bit of a frame, so the first period is bit 0
    localparam pos_t POS_RST = '{bpos: LAST_BIT, blk: LAST_BLK, sub: LAST_SUB};

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (sync_in) begin
            pos_d = '0;
        end else if (pos_q.bpos == LAST_BIT) begin
            pos_d.bpos = '0;
            if (pos_q.blk == LAST_BLK) begin
                pos_d.blk = '0;
                if (pos_q.sub == LAST_SUB) begin
                    pos_d.sub = '0;
                end else begin
                    pos_d.sub = pos_q.sub + 1'b1;
                end
            end else begin
                pos_d.blk = pos_q.blk + 1'b1;
            end
        end else begin
            pos_d.bpos = pos_q.bpos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= POS_RST;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign bit_pos  = pos_q.bpos;
    assign blk_pos  = pos_q.blk;
    assign sub_pos  = pos_q.sub;
    assign at_oh    = (pos_q.bpos == '0);
    assign at_start = (pos_q == '0);

endmodule

// File: rtl/ds3_slot_stage.sv
module ds3_slot_stage #(
    parameter  int unsigned BLKS  = ds3_align_pkg::BLOCKS_DEF,
    parameter  int unsigned SUBS  = ds3_align_pkg::SUBFRAMES_DEF,
    localparam int unsigned BLK_W = $clog2(BLKS),
    localparam int unsigned SUB_W = $clog2(SUBS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_data,
    input  logic             at_oh,
    input  logic             at_start,
    input  logic [BLK_W-1:0] blk_pos,
    input  logic [SUB_W-1:0] sub_pos,
    output logic             s1_data,
    output logic             s1_oh,
    output logic             s1_start,
    output logic [BLK_W-1:0] s1_blk,
    output logic [SUB_W-1:0] s1_sub
);

    typedef struct packed {
        logic             data;
        logic             oh;
        logic             start;
        logic [BLK_W-1:0] blk;
        logic [SUB_W-1:0] sub;
    } s1_t;

    s1_t s1_d, s1_q;

    always_comb begin
        s1_d       = s1_q;
        s1_d.data  = smp_data;
        s1_d.oh    = at_oh;
        s1_d.start = at_start;
        // Indices are only meaningful on a slot; hold them elsewhere
        if (at_oh) begin
            s1_d.blk = blk_pos;
            s1_d.sub = sub_pos;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
        end else begin
            s1_q <= s1_d;
        end
    end

    assign s1_data  = s1_q.data;
    assign s1_oh    = s1_q.oh;
    assign s1_start = s1_q.start;
    assign s1_blk   = s1_q.blk;
    assign s1_sub   = s1_q.sub;

endmodule

// File: rtl/ds3_nrz_stage.sv
module ds3_nrz_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic s1_data,
    input  logic s1_oh,
    input  logic s1_start,
    input  logic ext_oh_en,
    input  logic oh_bit,
    output logic nrz_out,
    output logic sync_out
);

    import ds3_align_pkg::*;

    typedef struct packed {
        logic nrz;
        logic sync;
    } out_t;

    out_t     out_d, out_q;
    nrz_src_e src;

    always_comb begin
        if (!s1_oh) begin
            src = SRC_PAYLOAD;
        end else if (ext_oh_en) begin
            src = SRC_OH_KEEP;
        end else begin
            src = SRC_OH_INSERT;
        end
    end

    always_comb begin
        out_d      = out_q;
        out_d.sync = s1_start;
        unique case (src)
            SRC_OH_INSERT: out_d.nrz = oh_bit;
            SRC_OH_KEEP:   out_d.nrz = s1_data;
            default:       out_d.nrz = s1_data;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign nrz_out  = out_q.nrz;
    assign sync_out = out_q.sync;

endmodule

// File: rtl/ds3_mframe_aligner.sv
module ds3_mframe_aligner #(
    parameter  int unsigned BLK_BITS = ds3_align_pkg::BLOCK_BITS_DEF,
    parameter  int unsigned BLKS     = ds3_align_pkg::BLOCKS_DEF,
    parameter  int unsigned SUBS     = ds3_align_pkg::SUBFRAMES_DEF,
    localparam int unsigned BIT_W    = $clog2(BLK_BITS),
    localparam int unsigned BLK_W    = $clog2(BLKS),
    localparam int unsigned SUB_W    = $clog2(SUBS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic             data_in,
    input  logic             ext_oh_en,
    input  logic             oh_bit,
    output logic             nrz_out,
    output logic             sync_out,
    output logic             oh_slot,
    output logic [SUB_W-1:0] sub_idx,
    output logic [BLK_W-1:0] blk_idx
);

    logic             smp_data;
    logic [BIT_W-1:0] bit_pos;
    logic [BLK_W-1:0] blk_pos;
    logic [SUB_W-1:0] sub_pos;
    logic             at_oh;
    logic             at_start;
    logic             s1_data;
    logic             s1_start;

    ds3_neg_sampler u_smp (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (data_in),
        .dout  (smp_data)
    );

    ds3_frame_counter #(
        .BLK_BITS (BLK_BITS),
        .BLKS     (BLKS),
        .SUBS     (SUBS)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_in),
        .bit_pos  (bit_pos),
        .blk_pos  (blk_pos),
        .sub_pos  (sub_pos),
        .at_oh    (at_oh),
        .at_start (at_start)
    );

    ds3_slot_stage #(
        .BLKS (BLKS),
        .SUBS (SUBS)
    ) u_s1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_data (smp_data),
        .at_oh    (at_oh),
        .at_start (at_start),
        .blk_pos  (blk_pos),
        .sub_pos  (sub_pos),
        .s1_data  (s1_data),
        .s1_oh    (oh_slot),
        .s1_start (s1_start),
        .s1_blk   (blk_idx),
        .s1_sub   (sub_idx)
    );

    ds3_nrz_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_data   (s1_data),
        .s1_oh     (oh_slot),
        .s1_start  (s1_start),
        .ext_oh_en (ext_oh_en),
        .oh_bit    (oh_bit),
        .nrz_out   (nrz_out),
        .sync_out  (sync_out)
    );

    // bit_pos is used only inside the counter's slot decode
    logic unused_bits;
    assign unused_bits = ^bit_pos;

endmodule

// File: rtl/ds3_align_checker.sv
module ds3_align_checker #(
    parameter  int unsigned BLKS  = 8,
    parameter  int unsigned SUBS  = 7,
    localparam int unsigned BLK_W = $clog2(BLKS),
    localparam int unsigned SUB_W = $clog2(SUBS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_in,
    input logic             smp_data,
    input logic             ext_oh_en,
    input logic             oh_bit,
    input logic             nrz_out,
    input logic             sync_out,
    input logic             oh_slot,
    input logic [SUB_W-1:0] sub_idx,
    input logic [BLK_W-1:0] blk_idx
);

    AST_PAYLOAD_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(oh_slot) |-> (nrz_out == $past(smp_data, 2))); // R2

    AST_OH_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(oh_slot) && !$past(ext_oh_en)) |-> (nrz_out == $past(oh_bit))); // R8

    AST_OH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(oh_slot) && $past(ext_oh_en)) |-> (nrz_out == $past(smp_data, 2))); // R9

    AST_SYNC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |=> ##2 sync_out); // R6

    AST_SYNC_ON_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> ($past(oh_slot) && ($past(blk_idx) == '0) && ($past(sub_idx) == '0))); // R7

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        oh_slot |-> ((int'(blk_idx) < int'(BLKS)) && (int'(sub_idx) < int'(SUBS)))); // R11

endmodule

bind ds3_mframe_aligner ds3_align_checker #(
    .BLKS (BLKS),
    .SUBS (SUBS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_in),
    .smp_data  (smp_data),
    .ext_oh_en (ext_oh_en),
    .oh_bit    (oh_bit),
    .nrz_out   (nrz_out),
    .sync_out  (sync_out),
    .oh_slot   (oh_slot),
    .sub_idx   (sub_idx),
    .blk_idx   (blk_idx)
);

// File: tb/ds3_mframe_aligner_tb.sv
module ds3_mframe_aligner_tb;

    localparam int BLK_BITS = 85;
    localparam int BLKS     = 8;
    localparam int SUBS     = 7;
    localparam int SUB_BITS = BLK_BITS * BLKS;
    localparam int FRAME    = SUB_BITS * SUBS;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sync_in;
    logic       data_in;
    logic       ext_oh_en;
    logic       oh_bit;
    logic       nrz_out;
    logic       sync_out;
    logic       oh_slot;
    logic [2:0] sub_idx;
    logic [2:0] blk_idx;

    always #5 clk = ~clk;

    ds3_mframe_aligner u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .data_in   (data_in),
        .ext_oh_en (ext_oh_en),
        .oh_bit    (oh_bit),
        .nrz_out   (nrz_out),
        .sync_out  (sync_out),
        .oh_slot   (oh_slot),
        .sub_idx   (sub_idx),
        .blk_idx   (blk_idx)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Reference model history (index 0 = current period, m1 = previous, m2 = two back)
    int pos_cur, pos_m1, pos_m2;
    bit d_cur, d_m1, d_m2;
    bit ohb_cur, ohb_m1;
    bit ext_cur, ext_m1;
    bit sync_prev;
    int warm;
    int per;
    int sync_cnt;
    int sync_first;
    int sync_last;
    int sync_gap_bad;
    logic [15:0] lf = 16'hACE1;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            if (n_bad < 30)
                $display("FAIL %s actual=%0d expected=%0d period=%0d", req, act, exp, per);
        end
    endtask

    function automatic bit rnd();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[0];
    endfunction

    // One bit period: drive at +1, check at +3, optional glitches after the falling edge
    task automatic step(input bit d, input bit sy, input bit ohb, input bit ext,
                        input bit dglitch, input bit sglitch, input string tag);
        bit exp_slot, oh2, exp_nrz, exp_sync;
        int exp_blk, exp_sub;
        string ntag;
        @(posedge clk);
        per++;
        pos_m2  = pos_m1;
        pos_m1  = pos_cur;
        pos_cur = sync_prev ? 0 : (pos_m1 + 1) % FRAME;
        d_m2    = d_m1;
        d_m1    = d_cur;
        ohb_m1  = ohb_cur;
        ext_m1  = ext_cur;
        warm++;
        #1;
        data_in   = d;
        sync_in   = sy;
        oh_bit    = ohb;
        ext_oh_en = ext;
        d_cur     = d;
        sync_prev = sy;
        ohb_cur   = ohb;
        ext_cur   = ext;
        #2;
        if (warm >= 1) begin
            exp_slot = (pos_m1 % BLK_BITS) == 0;
            chk("R7 oh_slot", oh_slot, exp_slot);
            if (exp_slot) begin
                exp_blk = (pos_m1 / BLK_BITS) % BLKS;
                exp_sub = pos_m1 / SUB_BITS;
                chk("R11 blk_idx", blk_idx, exp_blk);
                chk("R11 sub_idx", sub_idx, exp_sub);
            end
        end
        if (warm >= 2) begin
            oh2      = (pos_m2 % BLK_BITS) == 0;
            exp_nrz  = (oh2 && !ext_m1) ? ohb_m1 : d_m2;
            exp_sync = (pos_m2 == 0);
            if (!oh2)       ntag = {"R2 R10 nrz ", tag};
            else if (ext_m1) ntag = {"R9 nrz ", tag};
            else            ntag = {"R8 nrz ", tag};
            chk(ntag, nrz_out, exp_nrz);
            chk({"R6 sync_out ", tag}, sync_out, exp_sync);
            if (sync_out) begin
                if (sync_cnt == 0) sync_first = per;
                else if (per - sync_last != FRAME) sync_gap_bad++;
                sync_cnt++;
                sync_last = per;
            end
        end
        #3;
        if (dglitch) data_in = ~d;
        if (sglitch) sync_in = 1'b1;
        #2;
        if (sglitch) sync_in = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; sync_in = 1'b0; data_in = 1'b0; ext_oh_en = 1'b0; oh_bit = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        chk("R1 nrz_out", nrz_out, 0);
        chk("R1 sync_out", sync_out, 0);
        chk("R1 oh_slot", oh_slot, 0);
        chk("R1 sub_idx", sub_idx, 0);
        chk("R1 blk_idx", blk_idx, 0);
        @(posedge clk);
        #1;
        rst_n     = 1'b1;
        pos_cur   = FRAME - 1;
        d_cur     = 1'b0;
        ohb_cur   = 1'b0;
        ext_cur   = 1'b0;
        sync_prev = 1'b0;
        warm      = 0;
        per       = -1;
        sync_cnt  = 0;
        sync_last = 0;
        sync_gap_bad = 0;
    endtask

    task automatic t_free_run();
        t_reset();
        for (int i = 0; i < 2 * FRAME + 10; i++)
            step(rnd(), 1'b0, rnd(), 1'b0, 1'b0, 1'b0, "free");
        chk("R5 first sync period", sync_first, 2);
        chk("R5 sync count", sync_cnt, 3);
        chk("R5 sync spacing errors", sync_gap_bad, 0);
    endtask

    task automatic t_ext_sync();
        for (int i = 0; i < 1200; i++) begin
            bit sy;
            sy = (i == 100) || (i == 437) || (i == 438) || (i == 900);
            step(rnd(), sy, rnd(), 1'b0, 1'b0, 1'b0, "R4 ext sync");
        end
        for (int i = 0; i < FRAME + 20; i++)
            step(rnd(), 1'b0, rnd(), 1'b0, 1'b0, 1'b0, "after sync wrap");
    endtask

    task automatic t_sync_glitch();
        for (int i = 0; i < 400; i++)
            step(rnd(), 1'b0, rnd(), 1'b0, 1'b0, 1'b1, "R4 sync glitch");
    endtask

    task automatic t_data_glitch();
        for (int i = 0; i < 400; i++)
            step(rnd(), 1'b0, rnd(), 1'b0, 1'b1, 1'b0, "R3 data glitch");
    endtask

    task automatic t_ext_oh();
        for (int i = 0; i < 900; i++)
            step(rnd(), 1'b0, rnd(), 1'b1, 1'b0, 1'b0, "R9 keep");
        for (int i = 0; i < 400; i++)
            step(rnd(), 1'b0, rnd(), 1'b0, 1'b0, 1'b0, "R8 insert");
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_free_run();
        t_ext_sync();
        t_sync_glitch();
        t_data_glitch();
        t_ext_oh();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule